// File: doc/BRIEF.md
# Dual-Select Serial Slave Front End

This block is the slave side of a serial bus carrying two logical channels on one shared bit clock and one shared input line. The control channel is a register port behind its own active-low select. Each control frame holds an 8-bit opcode, an 8-bit register address and a 16-bit word. On a read, the block shifts the addressed register value back out on a serial output, and this output drives only during that phase. The data channel turns a serial stream into bytes.

Two configuration inputs set how the data channel finds its framing. In the default new mode it has its own active-low select. With the shared option on, it ignores that pin and treats itself as selected whenever the control select is high. In legacy mode it takes bits from a separate data clock and data pin, and a rising sync strobe marks the start of each byte. Control words and data bytes cross into the system clock domain through toggle handshakes and appear as one-cycle valid strobes. The register file that answers reads lives outside the block: it sees `rd_addr` and returns `rd_data`.

Top module: `spi_dual_front`

## Requirements
- R1: While `rst` is high, `ctrl_valid`, `data_valid` and `so_oe` are 0.
- R2: `so_oe` is 0 whenever `ctrl_cs_n` is high and throughout a write frame.
- R3: A control frame is 32 bits, MSB first, sampled on rising `sck` edges: opcode (8'h02 write, 8'h03 read), address, then a 16-bit word. A complete frame gives one `ctrl_valid` with `ctrl_write`, `ctrl_addr` and the received word on `ctrl_data`. Any other opcode gives no strobe and never enables `so`.
- R4: In a read frame, `rd_data` for the received address is presented MSB first on `so`, with `so_oe` high. Each bit changes on a falling `sck` edge, starting with the falling edge that follows the 16th rising edge.
- R5: Raising `ctrl_cs_n` before the 32nd bit discards the frame. The next frame starts again at its first bit.
- R6: In new mode the data channel shifts `si` in MSB first while its select is low. It gives one `data_valid` with the byte for every 8 bits, and many bytes may follow in one select period.
- R7: Bits of a byte left unfinished when the data select rises are discarded.
- R8: In new mode with `cfg_share_sel` = 1, the `data_cs_n` pin is ignored and the data channel is selected exactly while `ctrl_cs_n` is high.
- R9: While `ctrl_cs_n` is low, the data channel ignores all clocks, even if its own select is also low.
- R10: With `cfg_new_mode` = 0, data bits come from `sdata` on rising `dclk`. A byte begins at the bit sampled when `bsync` first reads high, and it ends after 8 bits. Bits taken without a fresh rising `bsync`, and all `sck` and `si` activity, produce no byte.
- R11: `sck` edges while both selects are high have no effect. A free-running clock behaves the same as a gated one.
- R12: Each completed word or byte gives exactly one single-cycle strobe in the `clk` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset |
| cfg_new_mode | input | 1 | 1: data channel uses its own select; 0: legacy sync framing |
| cfg_share_sel | input | 1 | 1: data select taken as inverse of control select |
| sck | input | 1 | Shared serial clock |
| si | input | 1 | Shared serial input |
| ctrl_cs_n | input | 1 | Control channel select, active low |
| data_cs_n | input | 1 | Data channel select, active low |
| dclk | input | 1 | Legacy data clock |
| sdata | input | 1 | Legacy data input |
| bsync | input | 1 | Legacy byte sync strobe |
| rd_data | input | 16 | Register value for `rd_addr` |
| rd_addr | output | 8 | Address of the current control frame |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output buffer enable for `so` |
| ctrl_valid | output | 1 | Control word strobe |
| ctrl_write | output | 1 | 1 for a write frame |
| ctrl_addr | output | 8 | Received address |
| ctrl_data | output | 16 | Received data word |
| data_valid | output | 1 | Data byte strobe |
| data_byte | output | 8 | Received data byte |

## Verification
The checks assume that serial items arrive far enough apart for each toggle to settle in the system domain before the next one: at least about four `clk` periods, which the bench exceeds with an 80 ns bit time. They also assume that select, sync and configuration inputs change only while the relevant clock is low, and that `rd_data` holds steady during a read frame. The stimulus changes every serial input on falling `clk` edges, with `sck` and `dclk` low, and changes the configuration only when the channels are quiet.

// File: rtl/spi_fe_pkg.sv
`timescale 1ns/1ps
package spi_fe_pkg;
    localparam int OP_W    = 8;
    localparam int ADDR_W  = 8;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = OP_W + ADDR_W + WORD_W;

    localparam logic [OP_W-1:0] OP_WRITE = 8'h02;
    localparam logic [OP_W-1:0] OP_READ  = 8'h03;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } ctrl_item_t;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction
endpackage

// File: rtl/spi_ctrl_port.sv
`timescale 1ns/1ps
module spi_ctrl_port
    import spi_fe_pkg::*;
(
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so,
    output logic              so_oe,
    output logic              frame_done,
    output ctrl_item_t        item
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int SR_W  = WORD_W - 1;
    localparam logic [CNT_W-1:0] OP_END     = CNT_W'(OP_W - 1);
    localparam logic [CNT_W-1:0] ADDR_END   = CNT_W'(OP_W + ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_START = CNT_W'(OP_W + ADDR_W);
    localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FINISHED   = CNT_W'(FRAME_W);

    logic              idle;
    logic [CNT_W-1:0]  cnt;
    logic [SR_W-1:0]   sr;
    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] out_sr;
    logic              out_en;

    // select high (or reset) parks the channel and abandons the frame
    assign idle = rst | cs_n;

    always_ff @(posedge sck or posedge idle) begin
        if (idle) begin
            cnt    <= '0;
            sr     <= '0;
            op_q   <= '0;
            addr_q <= '0;
        end else if (cnt != FINISHED) begin
            cnt <= cnt + CNT_W'(1);
            sr  <= {sr[SR_W-2:0], si};
            if (cnt == OP_END)   op_q   <= {sr[OP_W-2:0], si};
            if (cnt == ADDR_END) addr_q <= {sr[ADDR_W-2:0], si};
        end
    end

    // read data launches on falling edges, one half bit ahead of the master's sample
    always_ff @(negedge sck or posedge idle) begin
        if (idle) begin
            out_sr <= '0;
            out_en <= 1'b0;
        end else if (cnt == DATA_START && op_q == OP_READ) begin
            out_sr <= rd_data;
            out_en <= 1'b1;
        end else if (cnt == FINISHED) begin
            out_en <= 1'b0;
        end else if (out_en) begin
            out_sr <= {out_sr[WORD_W-2:0], 1'b0};
        end
    end

    assign rd_addr    = addr_q;
    assign so         = out_en & out_sr[WORD_W-1];
    assign so_oe      = out_en;
    assign frame_done = !idle && (cnt == LAST_BIT) && op_known(op_q);
    assign item.wr    = (op_q == OP_WRITE);
    assign item.addr  = addr_q;
    assign item.data  = {sr[WORD_W-2:0], si};
endmodule

// File: rtl/spi_data_rx.sv
`timescale 1ns/1ps
module spi_data_rx
    import spi_fe_pkg::*;
(
    input  logic              rst,
    input  logic              new_mode,
    input  logic              share_sel,
    input  logic              sck,
    input  logic              si,
    input  logic              data_cs_n,
    input  logic              ctrl_cs_n,
    input  logic              dclk,
    input  logic              sdata,
    input  logic              bsync,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] PARKED   = CNT_W'(BYTE_W);

    logic              bit_clk, bit_in, sel_n, hold, sync_q, start;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [BYTE_W-2:0] sr;

    assign bit_clk = new_mode ? sck : dclk;
    assign bit_in  = new_mode ? si  : sdata;
    assign sel_n   = share_sel ? ~ctrl_cs_n : data_cs_n;
    // control select low wins over any data framing
    assign hold    = rst | ~ctrl_cs_n | (new_mode & sel_n);
    assign start   = ~new_mode & bsync & ~sync_q;

    always_comb begin
        if (start)
            cnt_nx = CNT_W'(1);
        else if (cnt == LAST_BIT)
            cnt_nx = new_mode ? '0 : PARKED;
        else if (new_mode || (cnt != '0 && cnt != PARKED))
            cnt_nx = cnt + CNT_W'(1);
        else
            cnt_nx = cnt;
    end

    always_ff @(posedge bit_clk or posedge hold) begin
        if (hold) begin
            cnt    <= '0;
            sr     <= '0;
            sync_q <= 1'b0;
        end else begin
            cnt    <= cnt_nx;
            sr     <= {sr[BYTE_W-3:0], bit_in};
            sync_q <= bsync;
        end
    end

    assign byte_done = !hold && (cnt == LAST_BIT) && !start;
    assign byte_q    = {sr, bit_in};
endmodule

// File: rtl/spi_toggle_xfer.sv
`timescale 1ns/1ps
module spi_toggle_xfer #(
    parameter int W = 8
) (
    input  logic         rst,
    input  logic         s_clk,
    input  logic         s_fire,
    input  logic [W-1:0] s_data,
    input  logic         clk,
    output logic         m_valid,
    output logic [W-1:0] m_data
);
    localparam int SYNC_N = 3;

    logic              tog;
    logic [W-1:0]      held;
    logic [SYNC_N-1:0] sync;

    always_ff @(posedge s_clk or posedge rst) begin
        if (rst) begin
            tog  <= 1'b0;
            held <= '0;
        end else if (s_fire) begin
            tog  <= ~tog;
            held <= s_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync    <= '0;
            m_valid <= 1'b0;
            m_data  <= '0;
        end else begin
            sync    <= {sync[SYNC_N-2:0], tog};
            m_valid <= sync[SYNC_N-1] ^ sync[SYNC_N-2];
            if (sync[SYNC_N-1] ^ sync[SYNC_N-2]) m_data <= held;
        end
    end
endmodule

// File: rtl/spi_dual_front.sv
`timescale 1ns/1ps
module spi_dual_front
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_new_mode,
    input  logic              cfg_share_sel,
    input  logic              sck,
    input  logic              si,
    input  logic              ctrl_cs_n,
    input  logic              data_cs_n,
    input  logic              dclk,
    input  logic              sdata,
    input  logic              bsync,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so,
    output logic              so_oe,
    output logic              ctrl_valid,
    output logic              ctrl_write,
    output logic [ADDR_W-1:0] ctrl_addr,
    output logic [WORD_W-1:0] ctrl_data,
    output logic              data_valid,
    output logic [BYTE_W-1:0] data_byte
);
    ctrl_item_t        c_item, c_out;
    logic              c_fire, d_fire, d_clk;
    logic [BYTE_W-1:0] d_byte;

    spi_ctrl_port u_ctrl (
        .rst(rst), .sck(sck), .cs_n(ctrl_cs_n), .si(si), .rd_data(rd_data),
        .rd_addr(rd_addr), .so(so), .so_oe(so_oe), .frame_done(c_fire), .item(c_item)
    );

    spi_data_rx u_data (
        .rst(rst), .new_mode(cfg_new_mode), .share_sel(cfg_share_sel), .sck(sck), .si(si),
        .data_cs_n(data_cs_n), .ctrl_cs_n(ctrl_cs_n), .dclk(dclk), .sdata(sdata),
        .bsync(bsync), .byte_done(d_fire), .byte_q(d_byte)
    );

    assign d_clk = cfg_new_mode ? sck : dclk;

    spi_toggle_xfer #(.W($bits(ctrl_item_t))) u_cx (
        .rst(rst), .s_clk(sck), .s_fire(c_fire), .s_data(c_item),
        .clk(clk), .m_valid(ctrl_valid), .m_data(c_out)
    );

    spi_toggle_xfer #(.W(BYTE_W)) u_dx (
        .rst(rst), .s_clk(d_clk), .s_fire(d_fire), .s_data(d_byte),
        .clk(clk), .m_valid(data_valid), .m_data(data_byte)
    );

    assign ctrl_write = c_out.wr;
    assign ctrl_addr  = c_out.addr;
    assign ctrl_data  = c_out.data;
endmodule

// File: rtl/spi_dual_front_chk.sv
`timescale 1ns/1ps
module spi_dual_front_chk
    import spi_fe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctrl_cs_n,
    input logic              so_oe,
    input logic              ctrl_valid,
    input logic              data_valid,
    input logic              ctrl_write,
    input logic [ADDR_W-1:0] ctrl_addr,
    input logic [WORD_W-1:0] ctrl_data
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!ctrl_valid && !data_valid));

    assert_so_float_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_cs_n |-> !so_oe);

    assert_item_known_R3: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |-> !$isunknown({ctrl_write, ctrl_addr, ctrl_data}));

    assert_ctrl_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |=> !ctrl_valid);

    assert_data_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);
endmodule

bind spi_dual_front spi_dual_front_chk u_chk (
    .clk(clk), .rst(rst), .ctrl_cs_n(ctrl_cs_n), .so_oe(so_oe),
    .ctrl_valid(ctrl_valid), .data_valid(data_valid), .ctrl_write(ctrl_write),
    .ctrl_addr(ctrl_addr), .ctrl_data(ctrl_data)
);

// File: tb/sim_spi_dual_front.sv
`timescale 1ns/1ps
module sim_spi_dual_front;
    logic clk = 1'b0, rst = 1'b1;
    logic new_mode = 1'b1, share = 1'b0;
    logic sck = 1'b0, si = 1'b0, ctrl_cs_n = 1'b1, data_cs_n = 1'b1;
    logic dclk = 1'b0, sdata = 1'b0, bsync = 1'b0;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data;
    logic so, so_oe, ctrl_valid, ctrl_write, data_valid;
    logic [7:0]  ctrl_addr, data_byte;
    logic [15:0] ctrl_data;

    int checks = 0, errs = 0, stray = 0;
    bit done = 0;
    logic [24:0] cq[$];
    logic [7:0]  dq[$];

    always #4 clk = ~clk;

    // register file model: value derived from the address
    assign rd_data = {rd_addr, ~rd_addr};

    spi_dual_front u0 (
        .clk(clk), .rst(rst), .cfg_new_mode(new_mode), .cfg_share_sel(share),
        .sck(sck), .si(si), .ctrl_cs_n(ctrl_cs_n), .data_cs_n(data_cs_n),
        .dclk(dclk), .sdata(sdata), .bsync(bsync), .rd_data(rd_data),
        .rd_addr(rd_addr), .so(so), .so_oe(so_oe), .ctrl_valid(ctrl_valid),
        .ctrl_write(ctrl_write), .ctrl_addr(ctrl_addr), .ctrl_data(ctrl_data),
        .data_valid(data_valid), .data_byte(data_byte)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pop and compare as the strobes appear
    always @(negedge clk) begin
        logic [24:0] ce;
        logic [7:0]  de;
        if (!rst) begin
            if (ctrl_valid) begin
                if (cq.size() == 0) stray++;
                else begin
                    ce = cq.pop_front();
                    check({ctrl_write, ctrl_addr, ctrl_data} == ce, "R3", "control item",
                          {7'd0, ctrl_write, ctrl_addr, ctrl_data}, {7'd0, ce});
                end
            end
            if (data_valid) begin
                if (dq.size() == 0) stray++;
                else begin
                    de = dq.pop_front();
                    check(data_byte == de, "R6", "data byte", {24'd0, data_byte}, {24'd0, de});
                end
            end
        end
    end

    task automatic drained(input string tag);
        repeat (12) @(negedge clk);
        check(cq.size() == 0 && dq.size() == 0 && stray == 0, tag, "pending or stray items",
              cq.size() + dq.size() + stray, 0);
        stray = 0;
    endtask

    task automatic ctrl_frame(input logic [7:0] op, input logic [7:0] addr,
                              input logic [15:0] wd, input int nbits, input string tag);
        logic [31:0] fr;
        logic [15:0] rv;
        fr = {op, addr, wd};
        rv = {addr, ~addr};
        if (nbits == 32 && (op == 8'h02 || op == 8'h03))
            cq.push_back({op == 8'h02, addr, wd});
        ctrl_cs_n = 1'b0;
        #40;
        for (int i = 0; i < nbits; i++) begin
            si = fr[31-i];
            #24;
            if (op == 8'h03 && i >= 16)
                check(so_oe && so == rv[31-i], "R4", "read bit on so",
                      {30'd0, so_oe, so}, {30'd0, 1'b1, rv[31-i]});
            else if (i == 20)
                check(!so_oe, tag, "so enable outside read phase", {31'd0, so_oe}, 0);
            #16 sck = 1'b1;
            #40 sck = 1'b0;
        end
        #40 ctrl_cs_n = 1'b1;
        #40;
        check(!so_oe, "R2", "so enable after deselect", {31'd0, so_oe}, 0);
    endtask

    task automatic data_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            si = b[7-i];
            #40 sck = 1'b1;
            #40 sck = 1'b0;
        end
    endtask

    task automatic leg_byte(input logic [7:0] b, input bit sync);
        for (int i = 0; i < 8; i++) begin
            sdata = b[7-i];
            bsync = sync && (i == 0);
            #40 dclk = 1'b1;
            #40 dclk = 1'b0;
        end
        bsync = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(!ctrl_valid && !data_valid && !so_oe, "R1", "outputs during reset",
              {29'd0, ctrl_valid, data_valid, so_oe}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R11: idle clocks with both selects high
        for (int k = 0; k < 6; k++) begin
            si = 1'b1;
            #40 sck = 1'b1;
            #40 sck = 1'b0;
        end
        drained("R11");
        ctrl_frame(8'h02, 8'h5A, 16'hBEEF, 32, "R2");
        drained("R11");

        // R4: read frame
        ctrl_frame(8'h03, 8'h3C, 16'h0000, 32, "R2");
        ctrl_frame(8'h03, 8'hA1, 16'h1357, 32, "R2");
        drained("R4");

        // R3: unknown opcode gives nothing and never drives so
        ctrl_frame(8'h7F, 8'h22, 16'h4444, 32, "R3");
        drained("R3");

        // R5: aborted frame then a clean one
        ctrl_frame(8'h02, 8'h99, 16'hFFFF, 20, "R5");
        ctrl_frame(8'h02, 8'h11, 16'h1234, 32, "R5");
        drained("R5");

        // R6: stream of bytes in one select period
        dq.push_back(8'hA5); dq.push_back(8'h3C); dq.push_back(8'hFF);
        data_cs_n = 1'b0;
        #40;
        data_bits(8'hA5, 8); data_bits(8'h3C, 8); data_bits(8'hFF, 8);
        #40 data_cs_n = 1'b1;
        drained("R6");

        // R7: partial byte dropped
        dq.push_back(8'h81);
        data_cs_n = 1'b0;
        #40 data_bits(8'hF0, 5);
        #40 data_cs_n = 1'b1;
        #40 data_cs_n = 1'b0;
        #40 data_bits(8'h81, 8);
        #40 data_cs_n = 1'b1;
        drained("R7");

        // R9: both selects low, control wins
        data_cs_n = 1'b0;
        ctrl_frame(8'h02, 8'h77, 16'h0F0F, 32, "R9");
        data_cs_n = 1'b1;
        drained("R9");

        // R8: shared select, pin held high yet data channel live
        share = 1'b1;
        #40;
        dq.push_back(8'h6E);
        data_bits(8'h6E, 8);
        drained("R8");
        ctrl_frame(8'h02, 8'h42, 16'hC0DE, 32, "R8");
        drained("R8");
        share = 1'b0;
        #40;

        // R10: legacy framing
        new_mode = 1'b0;
        data_cs_n = 1'b0;
        #40;
        leg_byte(8'hFF, 1'b0);
        data_bits(8'hAA, 8);
        drained("R10");
        dq.push_back(8'hC4); dq.push_back(8'h2B);
        leg_byte(8'hC4, 1'b1);
        leg_byte(8'h2B, 1'b1);
        leg_byte(8'h55, 1'b0);
        drained("R10");
        ctrl_frame(8'h02, 8'h0C, 16'hA5A5, 32, "R10");
        drained("R12");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(100000 * 8);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule